// File: doc/BRIEF.md
# VT Path BIP-2 Error Monitor

This block watches one low-order virtual-tributary path and checks its path overhead once per superframe. The byte that opens each superframe (the V5 byte) carries two parity bits. These bits must match the interleaved even parity of every byte of the previous superframe. The monitor finds the mismatches and adds them to a running error count. The count is either one per mismatched parity bit or one per errored superframe. The monitor also counts received remote-error indications in a second counter. When errors are found it raises a request so the transmit side can return a remote error indication.

A performance-monitoring strobe moves both running counts into holding registers and restarts the running counts from zero. A saturate option sets what happens at the top of the range: the running counts either stop at their maximum or wrap to zero. While any path alarm is active (auto-AIS, loss of pointer, path AIS, loss of multiframe), all counts are forced to zero.

Top module: `vt_bip_mon`

## Requirements
- R1: On each valid byte with `sf_i` high (the V5 byte), V5 byte bit 7 is compared with the XOR of bits 7, 5, 3 and 1, and V5 byte bit 6 with the XOR of bits 6, 4, 2 and 0. Both XORs are taken over every valid byte from the previous V5 byte up to the byte before this one. The first V5 byte after reset is not checked.
- R2: With `bit_mode_i` = 1, each checked V5 byte adds the number of mismatched parity bits (0, 1 or 2) to the BIP running count.
- R3: With `bit_mode_i` = 0, each checked V5 byte that has at least one mismatch adds exactly 1 to the BIP running count.
- R4: `rei_req_o` is updated one cycle after each V5 byte. It is 1 only when that V5 byte was checked, had a mismatch, and `rei_en_i` was 1. It holds its value until the next V5 byte.
- R5: Each V5 byte whose bit 5 is 1 adds 1 to the REI running count, whether or not the parity was checked.
- R6: A cycle with `pm_strobe_i` = 1 copies both running counts into `bip_hold_o` (12 bits) and `rei_hold_o` (11 bits), which are visible in the next cycle. It also clears the running counts. Without a strobe or an alarm, the holding outputs do not change.
- R7: An increment in the same cycle as `pm_strobe_i` is not part of the snapshot. It becomes the first value of the new running count.
- R8: With `sat_i` = 1, a running count stops at its all-ones value (4095 or 2047). With `sat_i` = 0, it wraps modulo its width.
- R9: While any of `auto_ais_i`, `lop_i`, `ais_i` or `lom_i` is 1, both running counts and both holding outputs become 0 in the next cycle. Increments in that cycle are discarded.
- R10: During reset, `bip_hold_o`, `rei_hold_o` and `rei_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_i | input | 8 | Received path byte |
| byte_vld_i | input | 1 | `byte_i` holds a path byte |
| sf_i | input | 1 | Current valid byte is the V5 byte (superframe start) |
| bit_mode_i | input | 1 | 1: count errored bits, 0: count errored superframes |
| rei_en_i | input | 1 | Enables the REI request |
| sat_i | input | 1 | 1: running counts saturate, 0: wrap |
| pm_strobe_i | input | 1 | Performance-monitoring snapshot strobe |
| auto_ais_i | input | 1 | Auto-AIS alarm |
| lop_i | input | 1 | Loss-of-pointer alarm |
| ais_i | input | 1 | Path AIS alarm |
| lom_i | input | 1 | Loss-of-multiframe alarm |
| bip_hold_o | output | 12 | Held BIP-2 error count |
| rei_hold_o | output | 11 | Held REI count |
| rei_req_o | output | 1 | Request to send REI on the transmit side |

## Verification
The assertions assume that `sf_i` matters only together with `byte_vld_i`. They also assume that the alarm and strobe inputs are level samples taken at the clock, with no framing relation to the byte stream. The stimulus therefore drives `sf_i` only on the first valid byte of each superframe. It puts idle cycles with `byte_vld_i` low inside superframes, and it raises strobes and alarms on V5 bytes as well as between them. The bench forms the V5 parity bits from its own running parity, so each superframe carries exactly the mismatch pattern the bench intends.

// File: rtl/vt_bip_pkg.sv
package vt_bip_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned V5_P1   = 7;  // checked against odd-numbered bits
  localparam int unsigned V5_P2   = 6;  // checked against even-numbered bits
  localparam int unsigned V5_REI  = 5;

  function automatic logic [1:0] bip_of(input logic [BYTE_W-1:0] b);
    return {b[7] ^ b[5] ^ b[3] ^ b[1], b[6] ^ b[4] ^ b[2] ^ b[0]};
  endfunction
endpackage

// File: rtl/vt_bip_check.sv
module vt_bip_check
  import vt_bip_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              vld_i,
  input  logic              sf_i,
  output logic              v5_o,
  output logic              chk_o,
  output logic [1:0]        mis_o,
  output logic              rei_o
);
  logic [1:0] acc_q;
  logic       have_prev_q;

  assign v5_o  = vld_i & sf_i;
  assign chk_o = v5_o & have_prev_q;
  assign mis_o = chk_o ? ({byte_i[V5_P1], byte_i[V5_P2]} ^ acc_q) : 2'b00;
  assign rei_o = v5_o & byte_i[V5_REI];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      have_prev_q <= 1'b0;
    end else if (v5_o) begin
      acc_q       <= bip_of(byte_i);  // V5 starts the next coverage window
      have_prev_q <= 1'b1;
    end else if (vld_i) begin
      acc_q       <= acc_q ^ bip_of(byte_i);
    end
  end
endmodule

// File: rtl/vt_pm_counter.sv
module vt_pm_counter #(
  parameter int unsigned W     = 12,
  parameter int unsigned INC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  input  logic             snap_i,
  input  logic             clr_i,
  input  logic             sat_i,
  output logic [W-1:0]     hold_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] run_q;
  logic [W-1:0] base;
  logic [W:0]   sum;
  logic [W-1:0] run_d;

  assign base  = snap_i ? '0 : run_q;
  assign sum   = {1'b0, base} + {{(W + 1 - INC_W){1'b0}}, inc_i};
  assign run_d = (sat_i && sum[W]) ? MAX : sum[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      hold_o <= '0;
    end else if (clr_i) begin
      run_q  <= '0;
      hold_o <= '0;
    end else begin
      run_q <= run_d;
      if (snap_i) hold_o <= run_q;
    end
  end
endmodule

// File: rtl/vt_bip_mon.sv
module vt_bip_mon
  import vt_bip_pkg::*;
#(
  parameter int unsigned BIP_W = 12,
  parameter int unsigned REI_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  input  logic              sf_i,
  input  logic              bit_mode_i,
  input  logic              rei_en_i,
  input  logic              sat_i,
  input  logic              pm_strobe_i,
  input  logic              auto_ais_i,
  input  logic              lop_i,
  input  logic              ais_i,
  input  logic              lom_i,
  output logic [BIP_W-1:0]  bip_hold_o,
  output logic [REI_W-1:0]  rei_hold_o,
  output logic              rei_req_o
);
  logic       v5, chk, rei_rx, alarm;
  logic [1:0] mis, bip_inc;
  logic [0:0] rei_inc;

  vt_bip_check u_check (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .byte_i (byte_i),
    .vld_i  (byte_vld_i),
    .sf_i   (sf_i),
    .v5_o   (v5),
    .chk_o  (chk),
    .mis_o  (mis),
    .rei_o  (rei_rx)
  );

  assign alarm   = auto_ais_i | lop_i | ais_i | lom_i;
  assign bip_inc = bit_mode_i ? (2'(mis[1]) + 2'(mis[0])) : {1'b0, |mis};
  assign rei_inc = rei_rx;

  vt_pm_counter #(.W(BIP_W), .INC_W(2)) u_bip_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (bip_inc),
    .snap_i (pm_strobe_i),
    .clr_i  (alarm),
    .sat_i  (sat_i),
    .hold_o (bip_hold_o)
  );

  vt_pm_counter #(.W(REI_W), .INC_W(1)) u_rei_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (rei_inc),
    .snap_i (pm_strobe_i),
    .clr_i  (alarm),
    .sat_i  (sat_i),
    .hold_o (rei_hold_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rei_req_o <= 1'b0;
    else if (v5)  rei_req_o <= chk & rei_en_i & (|mis);
  end
endmodule

// File: rtl/vt_bip_mon_chk.sv
module vt_bip_mon_chk #(
  parameter int unsigned BIP_W = 12,
  parameter int unsigned REI_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       byte_i,
  input logic             byte_vld_i,
  input logic             sf_i,
  input logic             bit_mode_i,
  input logic             rei_en_i,
  input logic             sat_i,
  input logic             pm_strobe_i,
  input logic             auto_ais_i,
  input logic             lop_i,
  input logic             ais_i,
  input logic             lom_i,
  input logic [BIP_W-1:0] bip_hold_o,
  input logic [REI_W-1:0] rei_hold_o,
  input logic             rei_req_o
);
  logic alarm;
  assign alarm = auto_ais_i | lop_i | ais_i | lom_i;

  // R9
  alarm_clears_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm |=> (bip_hold_o == '0) && (rei_hold_o == '0));

  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pm_strobe_i && !alarm) |=> ($stable(bip_hold_o) && $stable(rei_hold_o)));

  // R4
  req_only_at_v5_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_vld_i && sf_i) |=> $stable(rei_req_o));

  // R4
  req_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && sf_i && !rei_en_i) |=> !rei_req_o);

  // R10
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (bip_hold_o == '0 && rei_hold_o == '0 && !rei_req_o));
endmodule

bind vt_bip_mon vt_bip_mon_chk #(.BIP_W(BIP_W), .REI_W(REI_W)) u_chk (.*);

// File: tb/tb_vt_bip_mon.sv
`timescale 1ns/1ps
module tb_vt_bip_mon;
  localparam int SF_LEN  = 4;
  localparam int BIP_MAX = 4095;
  localparam int REI_MAX = 2047;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] byte_i = '0;
  logic byte_vld_i = 0, sf_i = 0, bit_mode_i = 0, rei_en_i = 0, sat_i = 0;
  logic pm_strobe_i = 0, auto_ais_i = 0, lop_i = 0, ais_i = 0, lom_i = 0;
  logic [11:0] bip_hold_o;
  logic [10:0] rei_hold_o;
  logic rei_req_o;

  always #2.5 clk_i = ~clk_i;

  vt_bip_mon dut (.*);

  int n_chk = 0, n_err = 0;
  string tag = "R10";
  bit done = 0;

  // reference model state
  int m_run_b, m_run_r, m_hold_b, m_hold_r;
  bit m_p1, m_p0, m_prev, m_req;

  task automatic chk(input string t, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  function automatic int add_cnt(input int base, input int inc, input int mx);
    int s = base + inc;
    if (s > mx) s = sat_i ? mx : s - (mx + 1);
    return s;
  endfunction

  task automatic model_step();
    int ib = 0, ir = 0, e;
    bit a1, a0;
    a1 = byte_i[7] ^ byte_i[5] ^ byte_i[3] ^ byte_i[1];
    a0 = byte_i[6] ^ byte_i[4] ^ byte_i[2] ^ byte_i[0];
    if (byte_vld_i && sf_i) begin
      if (m_prev) begin
        e = int'(byte_i[7] != m_p1) + int'(byte_i[6] != m_p0);
        ib = bit_mode_i ? e : (e > 0 ? 1 : 0);
        m_req = rei_en_i && (e > 0);
      end else m_req = 0;
      ir = byte_i[5];
      m_p1 = a1; m_p0 = a0; m_prev = 1;
    end else if (byte_vld_i) begin
      m_p1 ^= a1; m_p0 ^= a0;
    end
    if (auto_ais_i || lop_i || ais_i || lom_i) begin
      m_run_b = 0; m_run_r = 0; m_hold_b = 0; m_hold_r = 0;
    end else if (pm_strobe_i) begin
      m_hold_b = m_run_b; m_hold_r = m_run_r;
      m_run_b = add_cnt(0, ib, BIP_MAX); m_run_r = add_cnt(0, ir, REI_MAX);
    end else begin
      m_run_b = add_cnt(m_run_b, ib, BIP_MAX); m_run_r = add_cnt(m_run_r, ir, REI_MAX);
    end
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk_i); #1;
    chk({tag, " bip_hold"}, int'(bip_hold_o), m_hold_b);
    chk({tag, " rei_hold"}, int'(rei_hold_o), m_hold_r);
    chk({tag, " rei_req"},  int'(rei_req_o),  int'(m_req));
  endtask

  task automatic idle(input bit pm = 0);
    byte_vld_i = 0; sf_i = 0; byte_i = 8'($urandom); pm_strobe_i = pm;
    cyc();
    pm_strobe_i = 0;
  endtask

  task automatic send_sf(input bit e1, input bit e0, input bit rei,
                         input bit pm = 0, input bit gaps = 0);
    byte_vld_i = 1; sf_i = 1; pm_strobe_i = pm;
    byte_i = {m_p1 ^ e1, m_p0 ^ e0, rei, 5'($urandom)};
    cyc();
    pm_strobe_i = 0; sf_i = 0;
    for (int i = 1; i < SF_LEN; i++) begin
      if (gaps && i == 2) begin idle(); byte_vld_i = 1; end
      byte_vld_i = 1; byte_i = 8'($urandom);
      cyc();
    end
  endtask

  task automatic err_mix();
    send_sf(0, 0, 0, 0, 1); send_sf(1, 0, 0, 0, 1); send_sf(1, 1, 0);
    send_sf(0, 1, 0, 0, 1); send_sf(0, 0, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R10 bip_hold", int'(bip_hold_o), 0);
    chk("R10 rei_hold", int'(rei_hold_o), 0);
    chk("R10 rei_req",  int'(rei_req_o), 0);
    rst_ni = 1;
    m_run_b = 0; m_run_r = 0; m_hold_b = 0; m_hold_r = 0;
    m_p1 = 0; m_p0 = 0; m_prev = 0; m_req = 0;

    // R1: first V5 unchecked even with wrong parity bits
    tag = "R1"; rei_en_i = 1;
    send_sf(~m_p1, ~m_p0, 0);
    idle(1);
    chk("R1 first V5 not checked", int'(bip_hold_o), 0);

    // R3 block mode
    tag = "R3"; bit_mode_i = 0;
    err_mix(); idle(1);
    chk("R3 block count", int'(bip_hold_o), 3);

    // R2 bit mode
    tag = "R2"; bit_mode_i = 1;
    err_mix(); idle(1);
    chk("R2 bit count", int'(bip_hold_o), 4);

    // R4 request gating
    tag = "R4"; rei_en_i = 0;
    send_sf(1, 1, 0); chk("R4 req off when disabled", int'(rei_req_o), 0);
    rei_en_i = 1;
    send_sf(0, 1, 0); chk("R4 req on error", int'(rei_req_o), 1);
    send_sf(0, 0, 0); chk("R4 req drops clean", int'(rei_req_o), 0);

    // R5 REI counting
    tag = "R5"; idle(1);
    send_sf(0, 0, 1); send_sf(1, 0, 1); send_sf(0, 0, 0); send_sf(0, 0, 1);
    idle(1);
    chk("R5 rei count", int'(rei_hold_o), 3);

    // R6 / R7 strobe coincident with increment
    tag = "R7"; bit_mode_i = 1;
    send_sf(1, 0, 1); send_sf(1, 1, 1, 1);
    chk("R7 snapshot excludes same-cycle inc", int'(bip_hold_o), 1);
    tag = "R6"; idle(); idle(1);
    chk("R6 new run keeps inc", int'(bip_hold_o), 2);
    chk("R6 rei new run", int'(rei_hold_o), 1);
    idle(1);
    chk("R6 cleared run", int'(bip_hold_o), 0);

    // R9 each alarm
    tag = "R9";
    for (int k = 0; k < 4; k++) begin
      send_sf(1, 1, 1); idle(1); send_sf(1, 1, 1);
      auto_ais_i = (k == 0); lop_i = (k == 1); ais_i = (k == 2); lom_i = (k == 3);
      send_sf(1, 1, 1);
      chk("R9 bip forced 0", int'(bip_hold_o), 0);
      chk("R9 rei forced 0", int'(rei_hold_o), 0);
      auto_ais_i = 0; lop_i = 0; ais_i = 0; lom_i = 0;
      idle(1);
      chk("R9 run cleared", int'(bip_hold_o), 0);
    end

    // R8 saturation
    tag = "R8"; sat_i = 1; bit_mode_i = 1; idle(1);
    for (int i = 0; i < 2100; i++) send_sf(1, 1, 1);
    idle(1);
    chk("R8 bip saturates", int'(bip_hold_o), BIP_MAX);
    chk("R8 rei saturates", int'(rei_hold_o), REI_MAX);

    // R8 wrap
    sat_i = 0;
    for (int i = 0; i < 2100; i++) send_sf(1, 1, 1);
    idle(1);
    chk("R8 bip wraps", int'(bip_hold_o), (2 * 2100) % 4096);
    chk("R8 rei wraps", int'(rei_hold_o), 2100 % 2048);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule